// File: doc/BRIEF.md
# SD Host Register Layout Translation Shim

This block sits between a 32-bit memory-mapped register bus and an SD host controller register file that uses the standard register layout. Software writes registers in a vendor layout. The shim rewrites each access on the fly so that the register file receives standard-layout data, and it rewrites host-control reads back into the vendor layout. Offsets that need no change pass through untouched.

Four kinds of offset get special handling:

- **Host control.** The bit fields of the host-control word are rearranged.
- **Mixed control.** A write only loads a shadow transfer-mode value. It causes no downstream access, so no command starts.
- **Transfer-mode/command word.** The shadow value is merged into the low half of the write, so the command is triggered exactly once.
- **Block size.** Every write has its DMA buffer boundary field forced to the largest setting.

A further set of vendor tuning and delay-line offsets read as zero and drop their writes. The shim holds two state registers: the shadow transfer mode and a cached power-control byte. It adds no latency. A forwarded access appears on the downstream port in the same cycle it is presented upstream, and read data returns combinationally.

Top module: `sdhc_layout_shim`

## Requirements
- R1: On a write to host control (offset 0x28), the forwarded standard byte 0 is built as follows. Bits 7, 6 and 0 are copied from the vendor word. Vendor bit 2 goes to bit 5 and vendor bit 1 stays at bit 1. Vendor bits 9:8 go to bits 4:3. Bit 2 is zero.
- R2: On a host-control write, bits 31:16 are forwarded unchanged and byte lane 0 is enabled when vendor lane 0 or lane 1 is enabled.
- R3: A host-control read returns the following vendor word. Bits 9:8 take standard bits 4:3, bit 2 takes standard bit 5, and bit 1 takes standard bit 1. Bits 15:10, 7:3 and 0 are zero. Bits 31:16 (block-gap and wakeup bytes) are passed unchanged.
- R4: The forwarded bits 15:8 of a host-control write equal the cached power-control byte. This byte resets to zero and is loaded from bits 15:8 of downstream read data on every host-control read.
- R5: A write to the mixed-control offset (0x48) makes no downstream request. It stores the enabled bytes of its low 16 bits into the shadow transfer-mode register.
- R6: A write to the command offset (0x0C) forwards its low 16 bits ORed with the shadow transfer mode. When either byte lane 2 or 3 is enabled, lanes 0 and 1 are enabled too.
- R7: A write to the block-size offset (0x04) forwards bits 14:12 as 3'b111; all other bits are unchanged.
- R8: Offsets 0x44, 0x48, 0x60, 0x68, 0x6C, 0xC0 and 0xCC read as zero without a downstream request. Writes to these offsets, other than 0x48, make no downstream request.
- R9: All other offsets pass through unchanged: request, direction, address, byte enables, write data and read data.
- R10: The busy-completion suppress output is high exactly when a forwarded command write enables lane 2 with response-type bits 17:16 equal to 2'b11. When it is high, the register file must not raise transfer-complete for that command alone.
- R11: After reset the shadow transfer mode is zero, so a first command write forwards its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Upstream access valid |
| up_we | input | 1 | Upstream write (1) or read (0) |
| up_addr | input | 8 | Upstream byte address, word aligned |
| up_be | input | 4 | Upstream byte lane enables (little-endian) |
| up_wdata | input | 32 | Upstream write data, vendor layout |
| up_rdata | output | 32 | Read data returned upstream, vendor layout |
| dn_req | output | 1 | Downstream access valid |
| dn_we | output | 1 | Downstream write (1) or read (0) |
| dn_addr | output | 8 | Downstream byte address |
| dn_be | output | 4 | Downstream byte lane enables |
| dn_wdata | output | 32 | Downstream write data, standard layout |
| dn_rdata | input | 32 | Read data from the register file |
| busy_nodone | output | 1 | Suppress transfer-complete for a busy-response command |

## Verification
The hardest situation to reach is a partial update of the shadow transfer mode that a later command write then merges. Reaching it needs a mixed-control write with only one lane enabled, followed by a command write whose own low half overlaps the shadow. The stimulus issues back-to-back mixed-control writes with random single-lane enables, then random command words. The bench keeps a byte-wise shadow model and compares the merged word and the widened lane enables. A second hard case is the power-control cache. The bench plants a random power byte in its register-file model, reads host control to load the cache, and then checks that the next host-control write carries that byte.

// File: rtl/sdhc_shim_pkg.sv
package sdhc_shim_pkg;

   typedef enum logic [2:0] {
      REG_PASS    = 3'd0,
      REG_HOSTCTL = 3'd1,
      REG_MIXMODE = 3'd2,
      REG_CMD     = 3'd3,
      REG_BLKSZ   = 3'd4,
      REG_SILENT  = 3'd5
   } shim_region_e;

   // vendor host-control half-word -> standard host-control byte
   function automatic logic [7:0] vendor_to_std_hc(input logic [15:0] v);
      return {v[7], v[6], v[2], v[9], v[8], 1'b0, v[1], v[0]};
   endfunction

   // standard host-control byte -> vendor host-control half-word
   function automatic logic [15:0] std_to_vendor_hc(input logic [7:0] s);
      return {6'b0, s[4], s[3], 5'b0, s[5], s[1], 1'b0};
   endfunction

endpackage

// File: rtl/sdhc_shim_decode.sv
module sdhc_shim_decode
   import sdhc_shim_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] HOSTCTL_OFS = 8'h28,
   parameter logic [ADDR_W-1:0] MIX_OFS     = 8'h48,
   parameter logic [ADDR_W-1:0] CMD_OFS     = 8'h0C,
   parameter logic [ADDR_W-1:0] BLKSZ_OFS   = 8'h04,
   parameter int unsigned ZERO_N      = 6,
   parameter logic [ZERO_N-1:0][ADDR_W-1:0] ZERO_OFS =
      {8'h44, 8'h60, 8'h68, 8'h6C, 8'hC0, 8'hCC}
)(
   input  logic [ADDR_W-1:0] addr,
   output shim_region_e      region
);

   localparam int unsigned WORD_MSB = ADDR_W - 1;

   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("sdhc_shim_decode: ADDR_W must be at least 3");
   end

   logic [ZERO_N-1:0] silent_hit;

   for (genvar i = 0; i < ZERO_N; i++) begin : g_silent
      if (ZERO_OFS[i][1:0] != 2'b00) begin : g_bad_align
         $error("sdhc_shim_decode: silent offset %0d is not word aligned", i);
      end
      assign silent_hit[i] = (addr[WORD_MSB:2] == ZERO_OFS[i][WORD_MSB:2]);
   end

   always_comb begin
      if (addr[WORD_MSB:2] == MIX_OFS[WORD_MSB:2])
         region = REG_MIXMODE;
      else if (|silent_hit)
         region = REG_SILENT;
      else if (addr[WORD_MSB:2] == HOSTCTL_OFS[WORD_MSB:2])
         region = REG_HOSTCTL;
      else if (addr[WORD_MSB:2] == CMD_OFS[WORD_MSB:2])
         region = REG_CMD;
      else if (addr[WORD_MSB:2] == BLKSZ_OFS[WORD_MSB:2])
         region = REG_BLKSZ;
      else
         region = REG_PASS;
   end

endmodule

// File: rtl/sdhc_shim_hostctl.sv
module sdhc_shim_hostctl
   import sdhc_shim_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] rdata_dn,
   output logic [DATA_W-1:0] fwd_wdata,
   output logic [LANES-1:0]  fwd_be,
   output logic [DATA_W-1:0] rd_xlat
);

   if (DATA_W != 32) begin : g_bad_width
      $error("sdhc_shim_hostctl: only a 32-bit word is supported");
   end

   // cached power-control byte, kept in step with the register file
   logic [7:0] pwr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pwr_q <= '0;
      else if (rd_hit)
         pwr_q <= rdata_dn[15:8];
   end

   assign fwd_wdata = {wdata[DATA_W-1:16], pwr_q, vendor_to_std_hc(wdata[15:0])};
   assign fwd_be    = {be[LANES-1:2], be[1], be[0] | be[1]};
   assign rd_xlat   = {rdata_dn[DATA_W-1:16], std_to_vendor_hc(rdata_dn[7:0])};

endmodule

// File: rtl/sdhc_shim_xfer.sv
module sdhc_shim_xfer #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LANES      = DATA_W / 8,
   parameter int unsigned MODE_W     = 16,
   parameter bit          BUSY_QUIRK = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mix_wr,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] fwd_wdata,
   output logic [LANES-1:0]  fwd_be,
   output logic              busy_nodone
);

   localparam int unsigned MODE_LANES = MODE_W / 8;
   localparam int unsigned RESP_LSB   = MODE_W;

   if (MODE_W % 8 != 0 || MODE_W >= DATA_W) begin : g_bad_mode
      $error("sdhc_shim_xfer: MODE_W must be whole bytes below DATA_W");
   end

   logic [MODE_W-1:0] mode_q;

   for (genvar l = 0; l < MODE_LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_q[l*8 +: 8] <= '0;
         else if (mix_wr && be[l])
            mode_q[l*8 +: 8] <= wdata[l*8 +: 8];
      end
   end

   logic cmd_lanes;
   assign cmd_lanes = |be[LANES-1:MODE_LANES];

   assign fwd_wdata = {wdata[DATA_W-1:MODE_W], wdata[MODE_W-1:0] | mode_q};
   assign fwd_be    = {be[LANES-1:MODE_LANES], be[MODE_LANES-1:0] | {MODE_LANES{cmd_lanes}}};

   if (BUSY_QUIRK) begin : g_busy_quirk
      assign busy_nodone = cmd_wr && be[MODE_LANES] &&
                           (wdata[RESP_LSB +: 2] == 2'b11);
   end else begin : g_no_quirk
      assign busy_nodone = 1'b0;
   end

endmodule

// File: rtl/sdhc_layout_shim.sv
module sdhc_layout_shim
   import sdhc_shim_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned BND_LSB       = 12,
   parameter int unsigned BND_W         = 3,
   parameter logic [BND_W-1:0] BND_CODE = 3'b111,
   parameter bit          BUSY_QUIRK    = 1'b1,
   parameter int unsigned LANES         = DATA_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_req,
   input  logic              up_we,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [LANES-1:0]  up_be,
   input  logic [DATA_W-1:0] up_wdata,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_req,
   output logic              dn_we,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [LANES-1:0]  dn_be,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata,
   output logic              busy_nodone
);

   if (BND_LSB + BND_W > DATA_W) begin : g_bad_bnd
      $error("sdhc_layout_shim: boundary field outside the data word");
   end

   shim_region_e region;

   sdhc_shim_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr   (up_addr),
      .region (region)
   );

   logic is_hc, is_mix, is_cmd, is_blk, is_silent;
   assign is_hc     = (region == REG_HOSTCTL);
   assign is_mix    = (region == REG_MIXMODE);
   assign is_cmd    = (region == REG_CMD);
   assign is_blk    = (region == REG_BLKSZ);
   assign is_silent = (region == REG_SILENT);

   logic [DATA_W-1:0] hc_wdata, hc_rdata, xf_wdata, blk_wdata;
   logic [LANES-1:0]  hc_be, xf_be;
   logic              xf_busy;

   sdhc_shim_hostctl #(.DATA_W(DATA_W)) u_hostctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_hit    (up_req && !up_we && is_hc),
      .wdata     (up_wdata),
      .be        (up_be),
      .rdata_dn  (dn_rdata),
      .fwd_wdata (hc_wdata),
      .fwd_be    (hc_be),
      .rd_xlat   (hc_rdata)
   );

   sdhc_shim_xfer #(.DATA_W(DATA_W), .BUSY_QUIRK(BUSY_QUIRK)) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mix_wr      (up_req && up_we && is_mix),
      .cmd_wr      (up_req && up_we && is_cmd),
      .wdata       (up_wdata),
      .be          (up_be),
      .fwd_wdata   (xf_wdata),
      .fwd_be      (xf_be),
      .busy_nodone (xf_busy)
   );

   always_comb begin
      blk_wdata = up_wdata;
      blk_wdata[BND_LSB +: BND_W] = BND_CODE;
   end

   // downstream request path
   assign dn_req  = up_req && !is_mix && !is_silent;
   assign dn_we   = up_we;
   assign dn_addr = up_addr;

   always_comb begin
      dn_wdata = up_wdata;
      dn_be    = up_be;
      if (up_we) begin
         unique case (region)
            REG_HOSTCTL: begin dn_wdata = hc_wdata; dn_be = hc_be; end
            REG_CMD:     begin dn_wdata = xf_wdata; dn_be = xf_be; end
            REG_BLKSZ:   dn_wdata = blk_wdata;
            default:     ;
         endcase
      end
   end

   // upstream read return
   always_comb begin
      unique case (region)
         REG_HOSTCTL:            up_rdata = hc_rdata;
         REG_MIXMODE, REG_SILENT: up_rdata = '0;
         default:                up_rdata = dn_rdata;
      endcase
   end

   assign busy_nodone = xf_busy;

   // ---------------------------------------------------------------
   // assertions
   // ---------------------------------------------------------------
   assert_hc_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_hc) |->
         (dn_wdata[4:3] == up_wdata[9:8]) && (dn_wdata[5] == up_wdata[2]) &&
         (dn_wdata[1] == up_wdata[1]) && !dn_wdata[2]);

   assert_hc_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_hc) |-> (dn_wdata[DATA_W-1:16] == up_wdata[DATA_W-1:16]));

   assert_hc_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && !up_we && is_hc) |->
         (up_rdata[9:8] == dn_rdata[4:3]) && (up_rdata[2] == dn_rdata[5]) && !up_rdata[0]);

   assert_pwr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_hc && $past(up_req && !up_we && is_hc)) |->
         (dn_wdata[15:8] == $past(dn_rdata[15:8])));

   assert_mix_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_mix) |-> !dn_req);

   assert_cmd_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_cmd && $past(up_req && up_we && is_mix && (up_be[1:0] == 2'b11))) |->
         (dn_wdata[15:0] == (up_wdata[15:0] | $past(up_wdata[15:0]))));

   assert_blk_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && up_we && is_blk) |->
         (dn_wdata[BND_LSB +: BND_W] == BND_CODE) && (dn_wdata[11:0] == up_wdata[11:0]));

   assert_silent_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && !up_we && (is_silent || is_mix)) |-> (up_rdata == '0) && !dn_req);

   assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (up_req && (region == REG_PASS)) |->
         dn_req && (dn_wdata == up_wdata) && (dn_be == up_be) && (up_rdata == dn_rdata));

   assert_busy_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_nodone |-> dn_req && dn_we && dn_be[2] && (dn_wdata[17:16] == 2'b11));

endmodule

// File: tb/sim_sdhc_layout_shim.sv
module sim_sdhc_layout_shim;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_req = 1'b0, up_we = 1'b0;
   logic [7:0]  up_addr = '0;
   logic [3:0]  up_be = '0;
   logic [31:0] up_wdata = '0;
   logic [31:0] up_rdata;
   logic        dn_req, dn_we;
   logic [7:0]  dn_addr;
   logic [3:0]  dn_be;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata;
   logic        busy_nodone;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2ns clk = ~clk;

   sdhc_layout_shim u0 (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_we(up_we), .up_addr(up_addr),
      .up_be(up_be), .up_wdata(up_wdata), .up_rdata(up_rdata), .dn_req(dn_req),
      .dn_we(dn_we), .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata),
      .dn_rdata(dn_rdata), .busy_nodone(busy_nodone)
   );

   // register file model behind the shim
   logic [31:0] rf [64];
   initial for (int i = 0; i < 64; i++) rf[i] = '0;
   assign dn_rdata = rf[dn_addr[7:2]];
   always @(posedge clk)
      if (dn_req && dn_we)
         for (int l = 0; l < 4; l++)
            if (dn_be[l]) rf[dn_addr[7:2]][l*8 +: 8] <= dn_wdata[l*8 +: 8];

   function automatic logic [7:0] exp_std(input logic [15:0] v);
      return {v[7], v[6], v[2], v[9], v[8], 1'b0, v[1], v[0]};
   endfunction

   function automatic logic [15:0] exp_vendor(input logic [7:0] s);
      logic [15:0] r = '0;
      r[9:8] = s[4:3]; r[2] = s[5]; r[1] = s[1];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      up_req = 1'b1; up_we = we; up_addr = a; up_be = be; up_wdata = d;
      #1ns;
   endtask

   task automatic quiet();
      @(negedge clk);
      up_req = 1'b0; up_we = 1'b0;
      #1ns;
   endtask

   initial begin
      #400us;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] shadow;
      logic [7:0]  pwr;
      logic [31:0] d;
      logic [3:0]  be;
      logic [7:0]  silent [7];
      logic [7:0]  pass [5];
      silent = '{8'h44, 8'h48, 8'h60, 8'h68, 8'h6C, 8'hC0, 8'hCC};
      pass   = '{8'h00, 8'h08, 8'h10, 8'h30, 8'h34};
      void'($urandom(32'd5150));
      shadow = '0;
      pwr = '0;

      repeat (3) @(posedge clk);
      #1ns;
      chk(dn_req == 1'b0 && busy_nodone == 1'b0, "R9 reset idle", {30'b0, dn_req, busy_nodone}, 32'h0);
      rst_n = 1'b1;

      // R11: first command write after reset is unchanged
      acc(1'b1, 8'h0C, 4'b1100, 32'h0A1A_0000);
      chk(dn_wdata == 32'h0A1A_0000, "R11 shadow zero", dn_wdata, 32'h0A1A_0000);
      chk(dn_be == 4'b1111, "R6 lane widen", {28'b0, dn_be}, 32'hF);

      // R1/R2: random host-control writes
      for (int i = 0; i < 20; i++) begin
         d = $urandom();
         be = (i < 2) ? 4'b0010 : 4'b1111;
         acc(1'b1, 8'h28, be, d);
         chk(dn_wdata[7:0] == exp_std(d[15:0]), "R1 hostctl byte", {24'b0, dn_wdata[7:0]}, {24'b0, exp_std(d[15:0])});
         chk(dn_wdata[31:16] == d[31:16] && dn_req, "R2 hostctl upper", dn_wdata, d);
         chk(dn_be == {be[3:2], be[1], be[0] | be[1]}, "R2 hostctl lanes", {28'b0, dn_be}, {28'b0, be[3:2], be[1], be[0] | be[1]});
         chk(dn_wdata[15:8] == pwr, "R4 pwr reset", {24'b0, dn_wdata[15:8]}, {24'b0, pwr});
      end

      // R3/R4: host-control reads with random register-file contents
      for (int i = 0; i < 10; i++) begin
         quiet();
         d = $urandom();
         rf[8'h28 >> 2] = d;
         acc(1'b0, 8'h28, 4'b1111, 32'h0);
         chk(up_rdata == {d[31:16], exp_vendor(d[7:0])}, "R3 hostctl read", up_rdata, {d[31:16], exp_vendor(d[7:0])});
         pwr = d[15:8];
         acc(1'b1, 8'h28, 4'b1111, 32'hFFFF_FFFF);
         chk(dn_wdata[15:8] == pwr, "R4 pwr cached", {24'b0, dn_wdata[15:8]}, {24'b0, pwr});
      end

      // R5/R6/R10: mixed-control shadow and command merge
      for (int i = 0; i < 24; i++) begin
         d = $urandom();
         be = (i % 3 == 0) ? 4'b0001 : (i % 3 == 1) ? 4'b0010 : 4'b1111;
         acc(1'b1, 8'h48, be, d);
         chk(dn_req == 1'b0, "R5 mix no request", {31'b0, dn_req}, 32'h0);
         if (be[0]) shadow[7:0] = d[7:0];
         if (be[1]) shadow[15:8] = d[15:8];
         d = $urandom();
         be = (i % 2 == 0) ? 4'b1100 : 4'b0111;
         acc(1'b1, 8'h0C, be, d);
         chk(dn_wdata == {d[31:16], d[15:0] | shadow}, "R6 command merge", dn_wdata, {d[31:16], d[15:0] | shadow});
         chk(dn_be == (be | 4'b0011), "R6 command lanes", {28'b0, dn_be}, {28'b0, be | 4'b0011});
         chk(busy_nodone == (be[2] && d[17:16] == 2'b11), "R10 busy flag", {31'b0, busy_nodone}, {31'b0, be[2] && d[17:16] == 2'b11});
      end
      acc(1'b1, 8'h0C, 4'b1100, 32'h0003_0000);
      chk(busy_nodone == 1'b1, "R10 busy response", {31'b0, busy_nodone}, 32'h1);
      acc(1'b1, 8'h0C, 4'b1100, 32'h0002_0000);
      chk(busy_nodone == 1'b0, "R10 plain response", {31'b0, busy_nodone}, 32'h0);
      acc(1'b1, 8'h28, 4'b1111, 32'h0003_0000);
      chk(busy_nodone == 1'b0, "R10 not command", {31'b0, busy_nodone}, 32'h0);

      // R7: block-size boundary forcing
      for (int i = 0; i < 10; i++) begin
         d = (i == 0) ? 32'h0000_0000 : $urandom();
         acc(1'b1, 8'h04, 4'b1111, d);
         chk(dn_wdata == (d | 32'h0000_7000), "R7 boundary forced", dn_wdata, d | 32'h0000_7000);
      end

      // R8: silent offsets
      foreach (silent[k]) begin
         quiet();
         rf[silent[k] >> 2] = 32'hDEAD_BEEF;
         acc(1'b0, silent[k], 4'b1111, 32'h0);
         chk(up_rdata == 32'h0 && !dn_req, "R8 silent read", up_rdata, 32'h0);
         acc(1'b1, silent[k], 4'b1111, $urandom());
         chk(!dn_req, "R8 silent write", {31'b0, dn_req}, 32'h0);
         quiet();
         chk(rf[silent[k] >> 2] == 32'hDEAD_BEEF, "R8 silent untouched", rf[silent[k] >> 2], 32'hDEAD_BEEF);
      end

      // R9: pass-through offsets
      foreach (pass[k]) begin
         d = $urandom();
         be = 4'($urandom());
         acc(1'b1, pass[k], be, d);
         chk(dn_req && dn_we && dn_addr == pass[k] && dn_wdata == d && dn_be == be, "R9 pass write", dn_wdata, d);
         quiet();
         d = $urandom();
         rf[pass[k] >> 2] = d;
         acc(1'b0, pass[k], 4'b1111, 32'h0);
         chk(up_rdata == d && dn_req && !dn_we, "R9 pass read", up_rdata, d);
      end

      quiet();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule